// File: doc/BRIEF.md
# Split-Word Accumulator ALU

This block holds a 32-bit accumulator kept as two 16-bit registers, an upper word and a lower word, together with a negative flag and a zero flag. Each cycle it can take one of three requests. A direct load replaces the whole accumulator. A binary request combines the accumulator with an operand port using a 3-bit operation code. A single-operand modify request is gated by a 4-bit condition tested against the current flags.

A binary operand is normally a 16-bit quantity that acts on the upper word: it is moved into bits 31..16 before the operation, so arithmetic carries and borrows run across the full 32 bits. When the wide marker is raised, the full 32-bit operand port is used as it stands. Every operation that changes state derives both flags from the whole 32-bit result. Results appear on the outputs after the next rising clock edge.

Top module: `acc_alu_top`

## Requirements
- R1: A synchronous active-high reset clears both accumulator words, N and Z, whatever requests are present in that cycle.
- R2: With aluValid high, code 1 subtracts, 4 adds, 5 ANDs, 6 ORs and 7 XORs the aligned operand with the accumulator, modulo 2^32. The result is visible on accFull after the next rising edge.
- R3: When aluWide is 0, only aluOperand[15:0] is used, placed in bits 31..16 with zeros below, and aluOperand[31:16] has no effect. When aluWide is 1, all 32 bits of aluOperand are used unshifted.
- R4: Code 3 (compare) computes accumulator minus aligned operand and updates N and Z from that difference. The accumulator keeps its value.
- R5: After any state-changing request, Z is 1 exactly when the 32-bit result is zero, and N equals bit 31 of the result.
- R6: A binary request with code 0 or 2 leaves the accumulator, N and Z unchanged. So does a cycle with no request.
- R7: Modify codes: 0 rotate right, 1 rotate left, 2 arithmetic shift right by one, 3 shift left by one, 4 increment, 5 decrement, 6 negate (two's complement), 7 absolute value (two's complement only when bit 31 is set). Each acts on all 32 bits and updates N and Z.
- R8: The rotates are circular over 32 bits. Right rotate moves bit 0 into bit 31, and left rotate moves bit 31 into bit 0.
- R9: A modify request runs only when its condition holds. Condition 0 always holds. Condition 5 holds when Z equals modPolarity. Condition 7 holds when N equals modPolarity. Every other condition is false, and the accumulator and flags keep their values.
- R10: A load writes loadValue[31:16] to the upper word and loadValue[15:0] to the lower word, and sets N and Z from the 32-bit value.
- R11: When requests coincide, a load wins over a binary request, and a binary request (of any code) wins over a modify. accHigh and accLow always equal the upper and lower halves of accFull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loadValid | input | 1 | Load request |
| loadValue | input | 32 | Value to load |
| aluValid | input | 1 | Binary request |
| aluOp | input | 3 | Binary operation code |
| aluWide | input | 1 | 1: operand used as 32 bits; 0: 16-bit operand aligned to upper word |
| aluOperand | input | 32 | Binary operand |
| modValid | input | 1 | Modify request |
| modOp | input | 3 | Modify operation code |
| modCond | input | 4 | Condition code gating the modify |
| modPolarity | input | 1 | Required flag state for conditions 5 and 7 |
| accHigh | output | 16 | Upper accumulator word |
| accLow | output | 16 | Lower accumulator word |
| accFull | output | 32 | Full accumulator |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |

## Verification
The hardest state to reach from the ports is a conditional modify whose flag test passes for the zero condition. Z is only set after a result that is exactly zero, and random 32-bit arithmetic almost never produces one. The stimulus therefore loads small values and draws operands from a narrow pool, so that subtractions and compares often land on zero. Directed cases cover the mismatch between a 16-bit operand that lands on the upper word and a borrow out of the lower word, and the bit that wraps around in each rotate.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    BIN_RSV0 = 3'd0,
    BIN_SUB  = 3'd1,
    BIN_RSV2 = 3'd2,
    BIN_CMP  = 3'd3,
    BIN_ADD  = 3'd4,
    BIN_AND  = 3'd5,
    BIN_OR   = 3'd6,
    BIN_XOR  = 3'd7
  } binOp_e;

  typedef enum logic [2:0] {
    MOD_ROR = 3'd0,
    MOD_ROL = 3'd1,
    MOD_SAR = 3'd2,
    MOD_SHL = 3'd3,
    MOD_INC = 3'd4,
    MOD_DEC = 3'd5,
    MOD_NEG = 3'd6,
    MOD_ABS = 3'd7
  } modOp_e;

  localparam logic [3:0] COND_ALWAYS = 4'd0;
  localparam logic [3:0] COND_ZFLAG  = 4'd5;
  localparam logic [3:0] COND_NFLAG  = 4'd7;

  typedef struct packed {
    logic   loadEn;
    logic   aluEn;
    logic   aluWrite;
    binOp_e aluOp;
    logic   wide;
    logic   modEn;
    modOp_e modOp;
  } strobes_t;

endpackage

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
  import acc_alu_pkg::*;
(
  input  logic [3:0] cond,
  input  logic       polarity,
  input  logic       flagN,
  input  logic       flagZ,
  output logic       pass
);
  always_comb begin
    unique case (cond)
      COND_ALWAYS: pass = 1'b1;
      COND_ZFLAG:  pass = (flagZ == polarity);
      COND_NFLAG:  pass = (flagN == polarity);
      default:     pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic       loadValid,
  input  logic       aluValid,
  input  logic [2:0] aluOp,
  input  logic       aluWide,
  input  logic       modValid,
  input  logic [2:0] modOp,
  input  logic [3:0] modCond,
  input  logic       modPolarity,
  input  logic       flagN,
  input  logic       flagZ,
  output strobes_t   strobes
);
  logic   condPass;
  logic   opKnown;
  binOp_e binOp;

  acc_alu_cond u_cond (
    .cond    (modCond),
    .polarity(modPolarity),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .pass    (condPass)
  );

  assign binOp = binOp_e'(aluOp);

  always_comb begin
    unique case (binOp)
      BIN_SUB, BIN_CMP, BIN_ADD, BIN_AND, BIN_OR, BIN_XOR: opKnown = 1'b1;
      default:                                             opKnown = 1'b0;
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.aluOp    = binOp;
    strobes.wide     = aluWide;
    strobes.modOp    = modOp_e'(modOp);
    strobes.loadEn   = loadValid;
    strobes.aluEn    = !loadValid && aluValid && opKnown;
    strobes.aluWrite = !loadValid && aluValid && opKnown && (binOp != BIN_CMP);
    strobes.modEn    = !loadValid && !aluValid && modValid && condPass;
  end
endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobes_t              strobes,
  input  logic [2*WORD_W-1:0]   loadValue,
  input  logic [2*WORD_W-1:0]   aluOperand,
  output logic [WORD_W-1:0]     accHigh,
  output logic [WORD_W-1:0]     accLow,
  output logic                  flagN,
  output logic                  flagZ
);
  localparam int ACC_W = 2 * WORD_W;

  logic [WORD_W-1:0] hiQ, loQ;
  logic              nQ, zQ;
  logic [ACC_W-1:0]  accCur;
  logic [ACC_W-1:0]  opAligned;
  logic [ACC_W-1:0]  binResult;
  logic [ACC_W-1:0]  modResult;
  logic [ACC_W-1:0]  flagSrc;
  logic [ACC_W-1:0]  accNext;
  logic              accWrite;
  logic              flagWrite;

  assign accCur    = {hiQ, loQ};
  assign opAligned = strobes.wide ? aluOperand
                                  : {aluOperand[WORD_W-1:0], {WORD_W{1'b0}}};

  always_comb begin
    unique case (strobes.aluOp)
      BIN_SUB, BIN_CMP: binResult = accCur - opAligned;
      BIN_ADD:          binResult = accCur + opAligned;
      BIN_AND:          binResult = accCur & opAligned;
      BIN_OR:           binResult = accCur | opAligned;
      BIN_XOR:          binResult = accCur ^ opAligned;
      default:          binResult = accCur;
    endcase
  end

  always_comb begin
    unique case (strobes.modOp)
      MOD_ROR: modResult = {accCur[0], accCur[ACC_W-1:1]};
      MOD_ROL: modResult = {accCur[ACC_W-2:0], accCur[ACC_W-1]};
      MOD_SAR: modResult = {accCur[ACC_W-1], accCur[ACC_W-1:1]};
      MOD_SHL: modResult = {accCur[ACC_W-2:0], 1'b0};
      MOD_INC: modResult = accCur + 1'b1;
      MOD_DEC: modResult = accCur - 1'b1;
      MOD_NEG: modResult = (~accCur) + 1'b1;
      MOD_ABS: modResult = accCur[ACC_W-1] ? ((~accCur) + 1'b1) : accCur;
      default: modResult = accCur;
    endcase
  end

  always_comb begin
    if (strobes.loadEn)     flagSrc = loadValue;
    else if (strobes.aluEn) flagSrc = binResult;
    else                    flagSrc = modResult;
    accNext   = flagSrc;
    accWrite  = strobes.loadEn || strobes.aluWrite || strobes.modEn;
    flagWrite = strobes.loadEn || strobes.aluEn || strobes.modEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hiQ <= '0;
      loQ <= '0;
      nQ  <= 1'b0;
      zQ  <= 1'b0;
    end else begin
      if (accWrite) begin
        hiQ <= accNext[ACC_W-1:WORD_W];
        loQ <= accNext[WORD_W-1:0];
      end
      if (flagWrite) begin
        nQ <= flagSrc[ACC_W-1];
        zQ <= (flagSrc == '0);
      end
    end
  end

  assign accHigh = hiQ;
  assign accLow  = loQ;
  assign flagN   = nQ;
  assign flagZ   = zQ;

  // R1: reset leaves everything cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (hiQ == '0 && loQ == '0 && !nQ && !zQ));

  // R6: no strobe, no change
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadEn && !strobes.aluEn && !strobes.modEn)
      |=> ($stable(hiQ) && $stable(loQ) && $stable(nQ) && $stable(zQ)));

  // R4: compare leaves the accumulator alone
  p_cmp_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (strobes.aluEn && !strobes.aluWrite) |=> ($stable(hiQ) && $stable(loQ)));

  // R10: a load splits into the two words
  p_load_split_r10: assert property (@(posedge clk) disable iff (rst)
    strobes.loadEn |=> ({hiQ, loQ} == $past(loadValue)));

  // R5: a written result and its flags agree
  p_flag_match_r5: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadEn || strobes.aluWrite || strobes.modEn)
      |=> (zQ == ({hiQ, loQ} == '0) && nQ == hiQ[WORD_W-1]));
endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
  import acc_alu_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int ACC_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadValid,
  input  logic [ACC_W-1:0]  loadValue,
  input  logic              aluValid,
  input  logic [2:0]        aluOp,
  input  logic              aluWide,
  input  logic [ACC_W-1:0]  aluOperand,
  input  logic              modValid,
  input  logic [2:0]        modOp,
  input  logic [3:0]        modCond,
  input  logic              modPolarity,
  output logic [WORD_W-1:0] accHigh,
  output logic [WORD_W-1:0] accLow,
  output logic [ACC_W-1:0]  accFull,
  output logic              flagN,
  output logic              flagZ
);
  strobes_t strobes;

  acc_alu_ctrl u_ctrl (
    .loadValid  (loadValid),
    .aluValid   (aluValid),
    .aluOp      (aluOp),
    .aluWide    (aluWide),
    .modValid   (modValid),
    .modOp      (modOp),
    .modCond    (modCond),
    .modPolarity(modPolarity),
    .flagN      (flagN),
    .flagZ      (flagZ),
    .strobes    (strobes)
  );

  acc_alu_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .loadValue (loadValue),
    .aluOperand(aluOperand),
    .accHigh   (accHigh),
    .accLow    (accLow),
    .flagN     (flagN),
    .flagZ     (flagZ)
  );

  assign accFull = {accHigh, accLow};

  // R11: at most one path acts per cycle
  p_one_path_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.loadEn, strobes.aluEn, strobes.modEn}));

  // R9: an unsupported condition never lets a modify through
  p_cond_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (modValid && !aluValid && !loadValid && modCond != 4'd0 && modCond != 4'd5
     && modCond != 4'd7) |=> ($stable(accFull) && $stable(flagN) && $stable(flagZ)));
endmodule

// File: tb/sim_acc_alu_top.sv
`timescale 1ns/1ps
module sim_acc_alu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadValid = 1'b0;
  logic [31:0] loadValue = '0;
  logic        aluValid = 1'b0;
  logic [2:0]  aluOp = '0;
  logic        aluWide = 1'b0;
  logic [31:0] aluOperand = '0;
  logic        modValid = 1'b0;
  logic [2:0]  modOp = '0;
  logic [3:0]  modCond = '0;
  logic        modPolarity = 1'b0;
  logic [15:0] accHigh, accLow;
  logic [31:0] accFull;
  logic        flagN, flagZ;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [31:0] mAcc = '0;
  logic        mN = 1'b0, mZ = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu_top u0 (
    .clk(clk), .rst(rst), .loadValid(loadValid), .loadValue(loadValue),
    .aluValid(aluValid), .aluOp(aluOp), .aluWide(aluWide), .aluOperand(aluOperand),
    .modValid(modValid), .modOp(modOp), .modCond(modCond), .modPolarity(modPolarity),
    .accHigh(accHigh), .accLow(accLow), .accFull(accFull), .flagN(flagN), .flagZ(flagZ)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit condHolds(logic [3:0] c, logic p, logic n, logic z);
    if (c == 4'd0) return 1'b1;
    if (c == 4'd5) return z == p;
    if (c == 4'd7) return n == p;
    return 1'b0;
  endfunction

  function automatic logic [31:0] modCalc(logic [2:0] op, logic [31:0] a);
    case (op)
      3'd0: return {a[0], a[31:1]};
      3'd1: return {a[30:0], a[31]};
      3'd2: return {a[31], a[31:1]};
      3'd3: return {a[30:0], 1'b0};
      3'd4: return a + 32'd1;
      3'd5: return a - 32'd1;
      3'd6: return 32'd0 - a;
      default: return a[31] ? 32'd0 - a : a;
    endcase
  endfunction

  // Advance the reference model by one cycle and return the requirement tag
  function automatic string modelStep();
    logic [31:0] opnd, res;
    if (rst) begin mAcc = '0; mN = 0; mZ = 0; return "R1"; end
    if (loadValid) begin
      mAcc = loadValue; mN = mAcc[31]; mZ = (mAcc == 0);
      return (aluValid || modValid) ? "R11" : "R10";
    end
    if (aluValid) begin
      opnd = aluWide ? aluOperand : {aluOperand[15:0], 16'h0};
      case (aluOp)
        3'd1, 3'd3: res = mAcc - opnd;
        3'd4: res = mAcc + opnd;
        3'd5: res = mAcc & opnd;
        3'd6: res = mAcc | opnd;
        3'd7: res = mAcc ^ opnd;
        default: return modValid ? "R11" : "R6";
      endcase
      mN = res[31]; mZ = (res == 0);
      if (aluOp != 3'd3) mAcc = res;
      if (modValid) return "R11";
      if (aluOp == 3'd3) return "R4";
      return aluWide ? "R2" : "R3";
    end
    if (modValid) begin
      if (!condHolds(modCond, modPolarity, mN, mZ)) return "R9";
      mAcc = modCalc(modOp, mAcc); mN = mAcc[31]; mZ = (mAcc == 0);
      return (modOp <= 3'd1) ? "R8" : "R7";
    end
    return "R6";
  endfunction

  task automatic runCycle();
    string tag;
    tag = modelStep();
    @(posedge clk);
    #1;
    check(tag, accFull, mAcc);
    check("R5", {30'd0, flagN, flagZ}, {30'd0, mN, mZ});
    check("R11", {accHigh, accLow}, accFull);
    @(negedge clk);
    loadValid = 0; aluValid = 0; modValid = 0;
  endtask

  task automatic doLoad(logic [31:0] v);
    loadValid = 1; loadValue = v; runCycle();
  endtask

  task automatic doAlu(logic [2:0] op, logic w, logic [31:0] v);
    aluValid = 1; aluOp = op; aluWide = w; aluOperand = v; runCycle();
  endtask

  task automatic doMod(logic [2:0] op, logic [3:0] c, logic p);
    modValid = 1; modOp = op; modCond = c; modPolarity = p; runCycle();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    void'($urandom(32'd20240527));
    @(negedge clk);
    loadValid = 1; loadValue = 32'hDEAD_BEEF;
    runCycle();           // R1: reset wins over a load
    rst = 0;
    runCycle();           // R6: idle after reset

    // R3: 16-bit operand hits the upper word; upper operand bits ignored
    doLoad(32'h0001_0000);
    doAlu(3'd1, 1'b0, 32'hFFFF_0001);
    // R3: borrow from the low word with a wide operand
    doLoad(32'h0001_0000);
    doAlu(3'd1, 1'b1, 32'h0000_0001);
    // R4: compare equal sets Z, keeps value
    doAlu(3'd3, 1'b1, 32'h0000_FFFF);
    // R6: reserved codes
    doAlu(3'd0, 1'b1, 32'h1234_5678);
    doAlu(3'd2, 1'b0, 32'h0000_4444);
    // R8: rotate wraparound bits
    doLoad(32'h0000_0001);
    doMod(3'd0, 4'd0, 1'b0);
    doMod(3'd1, 4'd0, 1'b0);
    doLoad(32'h8000_0000);
    doMod(3'd1, 4'd0, 1'b0);
    // R7: arithmetic shift right keeps sign, negate and abs
    doLoad(32'h8000_0002);
    doMod(3'd2, 4'd0, 1'b0);
    doMod(3'd7, 4'd0, 1'b0);
    doMod(3'd6, 4'd0, 1'b0);
    doMod(3'd7, 4'd0, 1'b0);
    // R9: unsupported conditions and mismatched polarity
    doMod(3'd4, 4'd3, 1'b1);
    doMod(3'd4, 4'd5, 1'b1);
    doMod(3'd4, 4'd7, 1'b1);
    // R9: zero condition passes when Z is set
    doLoad(32'h0000_0000);
    doMod(3'd5, 4'd5, 1'b1);
    doMod(3'd4, 4'd7, 1'b1);
    // R11: coincident requests
    loadValid = 1; loadValue = 32'h0F0F_0000; aluValid = 1; aluOp = 3'd4;
    aluWide = 1; aluOperand = 32'h1; modValid = 1; modOp = 3'd4; modCond = 0;
    runCycle();
    aluValid = 1; aluOp = 3'd2; modValid = 1; modOp = 3'd4; modCond = 0;
    runCycle();

    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      loadValid   = (sel == 0);
      loadValue   = ($urandom_range(0, 1) != 0) ? $urandom_range(0, 3) : $urandom;
      aluValid    = (sel >= 1 && sel <= 5) || (sel == 9);
      aluOp       = 3'($urandom_range(0, 7));
      aluWide     = 1'($urandom_range(0, 1));
      aluOperand  = ($urandom_range(0, 1) != 0) ? $urandom_range(0, 3) : $urandom;
      modValid    = (sel >= 6);
      modOp       = 3'($urandom_range(0, 7));
      modCond     = ($urandom_range(0, 3) != 0) ? 4'($urandom_range(0, 3) * 2 + 1) : 4'($urandom_range(0, 15));
      if (modCond == 4'd1 || modCond == 4'd3) modCond = 4'd0;
      modPolarity = 1'($urandom_range(0, 1));
      runCycle();
    end

    // R1: reset in mid-run
    rst = 1;
    runCycle();
    rst = 0;
    finish();
  end
endmodule